// File: doc/BRIEF.md
# Program/Erase Status Word Generator

This block forms the word a host sees when it reads a flash device while an embedded program or erase is running, while a sector erase is gathering sector addresses, or while an erase is suspended. A command controller, outside this block, supplies several inputs. One is the current activity mode. Another is a flag saying that the operation has run past its time limit. The controller also supplies bit 7 of the data most recently written by a program command, and a flag saying whether the address being read lies in a sector marked for erase. The block turns these into polling bits, two independent toggle bits, a time-limit bit and a window bit, plus an active-low ready/busy line.

Each toggle bit lives in its own flip-flop and advances only on a read strobe qualified by chip enable. The host can therefore see motion between two successive reads. The sector toggle moves only for reads inside sectors marked for erase. This lets the host tell an erasing or suspended sector apart from one that is untouched. In array-read mode, and for reads of other sectors while erase is suspended, the array word is passed through unchanged. A program or erase that targets only protected sectors is started with a pulse. The block then shows in-progress status for a fixed number of cycles and returns to the mode the controller gives.

Top module: `psw_status_gen`

## Requirements
- R1: With `op_mode` = 0 (array read), or the unused codes 6 and 7, a qualified read returns `array_data` unchanged and `ry_by_n` is 1.
- R2: With `op_mode` = 1 (program), a read returns bit 7 equal to the inverse of `pgm_bit7`, bits 3 and 2 at 0, every bit outside 7, 6, 5, 3 and 2 at 0, and `ry_by_n` at 0.
- R3: Bit 6 comes from a flip-flop that is 0 after reset and inverts after each qualified read (`rd_en` and `ce` both high) in modes 1, 2, 3 and 5. A read returns the value held before its own inversion.
- R4: In modes 1, 2, 3 and 5, bit 5 equals `time_over`, and bit 6 keeps inverting while `time_over` is 1.
- R5: In modes 2 (erase address window) and 3 (erase running), bit 7 reads 0. Bit 3 reads 0 in mode 2 and 1 in mode 3. `ry_by_n` is 0 in both modes.
- R6: Bit 2 comes from a second flip-flop that is 0 after reset. It inverts after each qualified read with `in_erase_sect` high in modes 2, 3 and 4, and holds otherwise. Modes 2 and 3 report its value for every address.
- R7: In mode 4 (erase suspended), a read with `in_erase_sect` high returns bit 7 = 1, bit 6 equal to the unmoving bit-6 flip-flop, bits 5 and 3 at 0, and bit 2 from its flip-flop. A read with `in_erase_sect` low returns `array_data`. `ry_by_n` is 1.
- R8: In mode 5 (program during erase suspend), a read returns bit 7 equal to the inverse of `pgm_bit7`, bit 6 inverting, bits 3 and 2 at 0, and `ry_by_n` at 0.
- R9: A `prot_start` pulse while no hold is running starts a hold of `PROT_HOLD` cycles. During the hold `ry_by_n` is 0 and reads show in-progress status as for mode 3 (if `prot_erase` was 1 at the pulse) or mode 1 (otherwise), whatever `op_mode` is. Afterwards `op_mode` governs again.
- R10: `rd_data` changes only on the clock edge that samples a qualified read. A read strobe with `ce` low changes neither `rd_data` nor either toggle. `ry_by_n` follows the mode one clock later.
- R11: Reset sets `rd_data` to 0, `ry_by_n` to 1 and both toggle flip-flops to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode | input | 3 | Activity mode: 0 read, 1 program, 2 erase window, 3 erase, 4 suspended, 5 suspended program |
| time_over | input | 1 | Operation has exceeded its time limit |
| pgm_bit7 | input | 1 | Bit 7 of the word being programmed |
| in_erase_sect | input | 1 | Read address lies in a sector marked for erase |
| rd_en | input | 1 | Read strobe |
| ce | input | 1 | Chip enable qualifying the read strobe |
| prot_start | input | 1 | Start of a program or erase aimed only at protected sectors |
| prot_erase | input | 1 | The protected-only operation is an erase |
| array_data | input | DATA_W | Word read from the array at the current address |
| rd_data | output | DATA_W | Registered read word |
| ry_by_n | output | 1 | Registered ready (1) / busy (0) |

## Verification
The hardest state to reach is the protected-only hold. It must overlap reads, and it overrides whatever mode the controller presents. The bench first pulses `prot_start` with the mode left at array read and counts the busy cycles exactly. It then pulses `prot_start` again and reads twice inside the hold, so that the bit-6 motion and the forced poll value are seen against a mode that would otherwise pass array data. The two toggle histories are also hard to keep apart. A sweep over every mode, sector flag, time flag and bit-7 value, with two reads per point, carries one running prediction for each toggle through the whole sequence.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic [2:0] {
    PM_READ     = 3'd0,
    PM_PROG     = 3'd1,
    PM_EWAIT    = 3'd2,
    PM_ERASE    = 3'd3,
    PM_SUSP     = 3'd4,
    PM_SUSP_PGM = 3'd5
  } psw_mode_e;

  localparam int BIT_POLL = 7;
  localparam int BIT_TGL  = 6;
  localparam int BIT_TMO  = 5;
  localparam int BIT_WIN  = 3;
  localparam int BIT_SECT = 2;

  localparam int NUM_TGL  = 2;
  localparam int TGL_OP   = 0;
  localparam int TGL_SECT = 1;
endpackage

// File: rtl/psw_toggle.sv
module psw_toggle (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (adv) q <= ~q;
  end
endmodule

// File: rtl/psw_hold_timer.sv
module psw_hold_timer #(
  parameter int PROT_HOLD = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_erase,
  output logic active,
  output logic is_erase
);
  localparam int CW = $clog2(PROT_HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(PROT_HOLD);

  logic [CW-1:0] cnt;

  assign active = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      is_erase <= 1'b0;
    end else if (!active && start) begin
      cnt      <= LOAD;
      is_erase <= start_erase;
    end else if (active) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/psw_compose.sv
module psw_compose
  import psw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  psw_mode_e          mode,
  input  logic               sel,
  input  logic               bit7,
  input  logic               tmo,
  input  logic               tgl_op,
  input  logic               tgl_sect,
  input  logic [DATA_W-1:0]  arr,
  output logic [DATA_W-1:0]  word,
  output logic               adv_op,
  output logic               adv_sect,
  output logic               ready
);
  always_comb begin
    word     = '0;
    adv_op   = 1'b0;
    adv_sect = 1'b0;
    ready    = 1'b0;
    unique case (mode)
      PM_PROG, PM_SUSP_PGM: begin
        word[BIT_POLL] = ~bit7;
        word[BIT_TGL]  = tgl_op;
        word[BIT_TMO]  = tmo;
        adv_op         = 1'b1;
      end
      PM_EWAIT, PM_ERASE: begin
        word[BIT_POLL] = 1'b0;
        word[BIT_TGL]  = tgl_op;
        word[BIT_TMO]  = tmo;
        word[BIT_WIN]  = (mode == PM_ERASE);
        word[BIT_SECT] = tgl_sect;
        adv_op         = 1'b1;
        adv_sect       = sel;
      end
      PM_SUSP: begin
        ready = 1'b1;
        if (sel) begin
          word[BIT_POLL] = 1'b1;
          word[BIT_TGL]  = tgl_op;
          word[BIT_SECT] = tgl_sect;
          adv_sect       = 1'b1;
        end else begin
          word = arr;
        end
      end
      default: begin
        word  = arr;
        ready = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/psw_status_gen.sv
module psw_status_gen
  import psw_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PROT_HOLD = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_mode,
  input  logic              time_over,
  input  logic              pgm_bit7,
  input  logic              in_erase_sect,
  input  logic              rd_en,
  input  logic              ce,
  input  logic              prot_start,
  input  logic              prot_erase,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              ry_by_n
);
  logic              hold_active;
  logic              hold_erase;
  logic              qual_rd;
  psw_mode_e         mode_in;
  psw_mode_e         mode_eff;
  logic [DATA_W-1:0] word_c;
  logic              ready_c;
  logic [NUM_TGL-1:0] tgl_q;
  logic [NUM_TGL-1:0] tgl_adv;
  logic [NUM_TGL-1:0] tgl_req;

  assign qual_rd = rd_en & ce;

  always_comb begin
    unique case (op_mode)
      3'd1:    mode_in = PM_PROG;
      3'd2:    mode_in = PM_EWAIT;
      3'd3:    mode_in = PM_ERASE;
      3'd4:    mode_in = PM_SUSP;
      3'd5:    mode_in = PM_SUSP_PGM;
      default: mode_in = PM_READ;
    endcase
  end

  assign mode_eff = hold_active ? (hold_erase ? PM_ERASE : PM_PROG) : mode_in;

  psw_hold_timer #(.PROT_HOLD(PROT_HOLD)) u_hold (
    .clk         (clk),
    .rst         (rst),
    .start       (prot_start),
    .start_erase (prot_erase),
    .active      (hold_active),
    .is_erase    (hold_erase)
  );

  psw_compose #(.DATA_W(DATA_W)) u_comp (
    .mode     (mode_eff),
    .sel      (in_erase_sect),
    .bit7     (pgm_bit7),
    .tmo      (time_over),
    .tgl_op   (tgl_q[TGL_OP]),
    .tgl_sect (tgl_q[TGL_SECT]),
    .arr      (array_data),
    .word     (word_c),
    .adv_op   (tgl_req[TGL_OP]),
    .adv_sect (tgl_req[TGL_SECT]),
    .ready    (ready_c)
  );

  for (genvar g = 0; g < NUM_TGL; g++) begin : g_tgl
    assign tgl_adv[g] = qual_rd & tgl_req[g];
    psw_toggle u_t (
      .clk (clk),
      .rst (rst),
      .adv (tgl_adv[g]),
      .q   (tgl_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      ry_by_n <= 1'b1;
    end else begin
      ry_by_n <= ready_c;
      if (qual_rd) rd_data <= word_c;
    end
  end
endmodule

// File: rtl/psw_status_chk.sv
module psw_status_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              ce,
  input logic [2:0]        op_mode,
  input logic              pgm_bit7,
  input logic [DATA_W-1:0] rd_data,
  input logic              ry_by_n,
  input logic              hold_active
);
  logic q;
  assign q = rd_en & ce;

  a_r10_stable_without_read: assert property (@(posedge clk) disable iff (rst)
    !q |=> $stable(rd_data));

  a_r2_poll_inverts: assert property (@(posedge clk) disable iff (rst)
    (q && op_mode == 3'd1 && !hold_active) |=> (rd_data[7] == !$past(pgm_bit7)));

  a_r5_erase_bits: assert property (@(posedge clk) disable iff (rst)
    (q && op_mode == 3'd3 && !hold_active) |=> (rd_data[7] == 1'b0 && rd_data[3] == 1'b1));

  a_r3_tgl_moves: assert property (@(posedge clk) disable iff (rst)
    (q && op_mode == 3'd1 && !hold_active) ##1 (q && op_mode == 3'd1 && !hold_active)
      |=> (rd_data[6] != $past(rd_data[6])));

  a_r1_read_ready: assert property (@(posedge clk) disable iff (rst)
    (op_mode == 3'd0 && !hold_active) |=> ry_by_n);

  a_r7_susp_ready: assert property (@(posedge clk) disable iff (rst)
    (op_mode == 3'd4 && !hold_active) |=> ry_by_n);

  a_r9_hold_busy: assert property (@(posedge clk) disable iff (rst)
    hold_active |=> !ry_by_n);
endmodule

bind psw_status_gen psw_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rd_en       (rd_en),
  .ce          (ce),
  .op_mode     (op_mode),
  .pgm_bit7    (pgm_bit7),
  .rd_data     (rd_data),
  .ry_by_n     (ry_by_n),
  .hold_active (hold_active)
);

// File: tb/psw_status_gen_tb.sv
`timescale 1ns/1ps
module psw_status_gen_tb;
  localparam int DW = 16;
  localparam int PH = 24;

  logic          clk = 1'b0;
  logic          rst;
  logic [2:0]    op_mode;
  logic          time_over, pgm_bit7, in_erase_sect, rd_en, ce, prot_start, prot_erase;
  logic [DW-1:0] array_data;
  logic [DW-1:0] rd_data;
  logic          ry_by_n;

  int checks = 0;
  int errors = 0;
  bit t6 = 0;
  bit t2 = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  psw_status_gen #(.DATA_W(DW), .PROT_HOLD(PH)) u_dut (
    .clk(clk), .rst(rst), .op_mode(op_mode), .time_over(time_over),
    .pgm_bit7(pgm_bit7), .in_erase_sect(in_erase_sect), .rd_en(rd_en), .ce(ce),
    .prot_start(prot_start), .prot_erase(prot_erase), .array_data(array_data),
    .rd_data(rd_data), .ry_by_n(ry_by_n)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected read word from the requirements, with toggle prediction.
  function automatic logic [DW-1:0] predict(input int m, input bit b7, input bit sel,
                                            input bit tmo, input logic [DW-1:0] arr);
    logic [DW-1:0] w = '0;
    if (m == 1 || m == 5) begin
      w[7] = ~b7; w[6] = t6; w[5] = tmo; t6 = ~t6;
    end else if (m == 2 || m == 3) begin
      w[7] = 1'b0; w[6] = t6; w[5] = tmo; w[3] = (m == 3); w[2] = t2;
      t6 = ~t6; if (sel) t2 = ~t2;
    end else if (m == 4) begin
      if (sel) begin w[7] = 1'b1; w[6] = t6; w[2] = t2; t2 = ~t2; end
      else w = arr;
    end else begin
      w = arr;
    end
    return w;
  endfunction

  function automatic bit ready_of(input int m);
    return (m == 0 || m == 4 || m >= 6);
  endfunction

  function automatic string req_of(input int m, input bit sel);
    case (m)
      1: return "R2/R3/R4";
      2, 3: return "R5/R6/R4";
      4: return sel ? "R7/R6" : "R7";
      5: return "R8/R3";
      default: return "R1";
    endcase
  endfunction

  task automatic do_read();
    rd_en = 1'b1; ce = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0; ce = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] exp;
    logic [DW-1:0] held;
    int lows;
    rst = 1'b1; op_mode = 3'd0; time_over = 0; pgm_bit7 = 0; in_erase_sect = 0;
    rd_en = 0; ce = 0; prot_start = 0; prot_erase = 0; array_data = 16'h1234;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check("R11 rd_data", rd_data, '0);
    check("R11 ry_by_n", {15'd0, ry_by_n}, 16'd1);
    rst = 1'b0;
    @(negedge clk);

    // Sweep every mode, sector flag, time flag and bit-7 value; two reads each.
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 8; k++) begin
        op_mode = 3'(m);
        pgm_bit7 = k[0]; in_erase_sect = k[1]; time_over = k[2];
        array_data = 16'hA5C3 ^ DW'((m * 8 + k) * 16'h1357);
        for (int r = 0; r < 2; r++) begin
          exp = predict(m, k[0], k[1], k[2], array_data);
          do_read();
          check(req_of(m, k[1]), rd_data, exp);
          check("R10 ready follows mode", {15'd0, ry_by_n}, {15'd0, ready_of(m)});
        end
      end
    end

    // R10: strobe with chip enable low moves nothing
    op_mode = 3'd1; pgm_bit7 = 1'b0; time_over = 1'b0;
    held = rd_data;
    rd_en = 1'b1; ce = 1'b0;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    check("R10 ce low keeps rd_data", rd_data, held);
    exp = predict(1, 1'b0, 1'b0, 1'b0, array_data);
    do_read();
    check("R10 ce low keeps toggle (R3)", rd_data, exp);

    // R9: protected-only hold duration, mode left at array read
    op_mode = 3'd0;
    @(negedge clk);
    prot_start = 1'b1; prot_erase = 1'b0;
    @(posedge clk); @(negedge clk);
    prot_start = 1'b0;
    lows = 0;
    for (int c = 0; c < PH + 4; c++) begin
      if (!ry_by_n) lows++;
      @(negedge clk);
    end
    check("R9 busy cycles", 16'(lows), 16'(PH));
    check("R9 ready after hold", {15'd0, ry_by_n}, 16'd1);

    // R9: reads during a program-style hold show poll status, not array data
    prot_start = 1'b1; prot_erase = 1'b0; pgm_bit7 = 1'b1;
    @(posedge clk); @(negedge clk);
    prot_start = 1'b0;
    for (int r = 0; r < 2; r++) begin
      exp = predict(1, 1'b1, 1'b0, 1'b0, array_data);
      do_read();
      check("R9 program hold status", rd_data, exp);
    end
    repeat (PH + 2) @(negedge clk);
    exp = predict(0, 1'b1, 1'b0, 1'b0, array_data);
    do_read();
    check("R9 array after hold (R1)", rd_data, exp);

    // R9: erase-style hold with mode at erase-suspend and sector selected
    op_mode = 3'd4; in_erase_sect = 1'b1;
    prot_start = 1'b1; prot_erase = 1'b1;
    @(posedge clk); @(negedge clk);
    prot_start = 1'b0;
    exp = predict(3, 1'b1, 1'b1, 1'b0, array_data);
    do_read();
    check("R9 erase hold status", rd_data, exp);
    check("R9 busy in hold", {15'd0, ry_by_n}, 16'd0);
    repeat (PH + 2) @(negedge clk);
    check("R7 ready after hold", {15'd0, ry_by_n}, 16'd1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule